// File: doc/BRIEF.md
# Sensor Line Timing Pulse Generator

This block keeps the horizontal (pixel) and vertical (line) position of an area image sensor readout. From those positions it builds three per-line pulses: an optical black clamp, a pixel blank and a horizontal blank. It runs on the pixel master clock. Active-low horizontal and vertical sync inputs restart the counts: a falling edge of horizontal sync starts a new line and a falling edge of vertical sync starts a new field.

Each pulse has a programmed turn-on position and turn-off position, written through a simple parallel register port. Writes go into a staging copy. The working copy is updated only at a vertical sync edge, so every field runs with one consistent set of positions.

A mode input chooses what the pixel counter does at its top value. In wrap mode it rolls over to zero. In hold mode it stays at the top value until the next horizontal sync. Hold mode supports lines longer than the counter range: the sampling enable stays on, and all pulses keep their levels.

Top module: `line_pulse_gen`

## Requirements
- R1: While reset is asserted, both counts read 0, all three pulses are low and the sampling enable is low.
- R2: On the clock edge that samples a falling edge of horizontal sync, the pixel count becomes 0. It then rises by one on each clock. Holding horizontal sync low for more cycles does not restart it again.
- R3: A falling edge of vertical sync sets the line count to 0. Otherwise each horizontal sync falling edge raises the line count by one. When both edges arrive together, the line count becomes 0.
- R4: In wrap mode, the pixel count goes from 4095 to 0 on the next clock.
- R5: In hold mode, the pixel count stays at 4095 until the next horizontal sync falling edge, which sets it to 0.
- R6: The mode input is captured on the first clock edge after reset is released (0 = wrap, 1 = hold). Later changes have no effect until the next reset.
- R7: A pulse goes high in the same cycle in which the pixel count output equals its turn-on position. It goes low in the cycle in which the count equals its turn-off position. If both positions are equal, turn-on wins. Otherwise the pulse keeps its level. Register addresses are: 0/1 for clamp on/off, 2/3 for pixel blank on/off, 4/5 for horizontal blank on/off. Addresses 6 and 7 are ignored. All positions reset to 0.
- R8: While the pixel count is held at 4095 in hold mode, every pulse keeps its level and the sampling enable stays high.
- R9: A written position takes effect only from the first pixel after the next vertical sync falling edge. Horizontal syncs before that edge keep the old positions.
- R10: The sampling enable goes high after the first horizontal sync falling edge and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sat_mode_i | input | 1 | Overflow policy: 0 wrap, 1 hold (captured after reset) |
| hsync_n_i | input | 1 | Active-low horizontal sync |
| vsync_n_i | input | 1 | Active-low vertical sync |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 12 | Position to write |
| hcount_o | output | 12 | Pixel position in line |
| vcount_o | output | 12 | Line position in field |
| clamp_o | output | 1 | Optical black clamp pulse |
| pblank_o | output | 1 | Pixel blanking pulse |
| hblank_o | output | 1 | Horizontal blanking pulse |
| sample_en_o | output | 1 | Sampling clock enable |

## Verification
The bench targets these corners:

- **Top value of the pixel counter, in both modes.** A design that confused the two modes would either freeze a line that should wrap or restart a long line in the middle.
- **Hold mode at 4095.** It checks that a pulse whose turn-on position is 4095 stays set. A design that re-evaluated the comparators while held could toggle a pulse or clear it.
- **Mode changed after capture.** It changes the mode input after it has been captured, to catch a design that reads the mode live.
- **Mid-field position writes.** It writes positions in the middle of a field and crosses a horizontal sync before the vertical one. A design without the shadow copy would move the clamp edge within the field.
- **Sync timing cases.** It holds horizontal sync low for several cycles, fires both syncs together, and programs equal on and off positions. These expose level-triggered restarts, a wrong sync priority, and a wrong comparator priority.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int CNT_W_DEF = 12;
  localparam int NUM_PULSE = 3;
  localparam int NUM_REG   = 2 * NUM_PULSE;
  localparam int ADDR_W    = $clog2(NUM_REG + 1);

  typedef enum logic [1:0] {
    PULSE_CLAMP  = 2'd0,
    PULSE_PBLANK = 2'd1,
    PULSE_HBLANK = 2'd2
  } pulse_id_e;
endpackage

// File: rtl/lpg_edge_det.sv
module lpg_edge_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_n_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= sig_n_i;
  end

  assign fall_o = prev_q & ~sig_n_i;
endmodule

// File: rtl/lpg_counters.sv
module lpg_counters #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_fall_i,
  input  logic             vs_fall_i,
  input  logic             hold_mode_i,
  output logic [CNT_W-1:0] hcount_o,
  output logic [CNT_W-1:0] vcount_o,
  output logic [CNT_W-1:0] hcount_nxt_o,
  output logic             advance_o
);
  localparam logic [CNT_W-1:0] H_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] h_q, h_d, v_q, v_d;
  logic             at_top;

  always_comb begin
    at_top = (h_q == H_TOP);
    if (hs_fall_i)   h_d = '0;
    else if (at_top) h_d = hold_mode_i ? H_TOP : '0;
    else             h_d = h_q + 1'b1;
    advance_o = hs_fall_i | ~at_top | ~hold_mode_i;
    if (vs_fall_i)      v_d = '0;
    else if (hs_fall_i) v_d = v_q + 1'b1;
    else                v_d = v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign hcount_o     = h_q;
  assign vcount_o     = v_q;
  assign hcount_nxt_o = h_d;
endmodule

// File: rtl/lpg_shadow_regs.sv
module lpg_shadow_regs #(
  parameter int CNT_W  = 12,
  parameter int NREG   = 6,
  parameter int ADDR_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  input  logic                       load_i,
  output logic [NREG-1:0][CNT_W-1:0] act_nxt_o
);
  logic [NREG-1:0][CNT_W-1:0] stage_q, act_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic stage_en;
    assign stage_en     = wr_en_i && (wr_addr_i == ADDR_W'(r));
    assign act_nxt_o[r] = load_i ? stage_q[r] : act_q[r];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[r] <= '0;
        act_q[r]   <= '0;
      end else begin
        if (stage_en) stage_q[r] <= wr_data_i;
        if (load_i)   act_q[r]   <= stage_q[r];
      end
    end
  end
endmodule

// File: rtl/lpg_pulse_cmp.sv
module lpg_pulse_cmp #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  input  logic [CNT_W-1:0] hcount_nxt_i,
  input  logic [CNT_W-1:0] on_pos_i,
  input  logic [CNT_W-1:0] off_pos_i,
  output logic             pulse_o
);
  logic p_q, p_d;

  always_comb begin
    p_d = p_q;
    if (advance_i) begin
      if (hcount_nxt_i == on_pos_i)       p_d = 1'b1;
      else if (hcount_nxt_i == off_pos_i) p_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= 1'b0;
    else        p_q <= p_d;
  end

  assign pulse_o = p_q;
endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
  import lpg_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sat_mode_i,
  input  logic              hsync_n_i,
  input  logic              vsync_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  hcount_o,
  output logic [CNT_W-1:0]  vcount_o,
  output logic              clamp_o,
  output logic              pblank_o,
  output logic              hblank_o,
  output logic              sample_en_o
);
  logic [1:0]                      falls;
  logic                            hs_fall, vs_fall;
  logic                            armed_q, mode_q, line_q, line_d;
  logic [CNT_W-1:0]                h_nxt;
  logic                            advance;
  logic [NUM_REG-1:0][CNT_W-1:0]   pos;
  logic [NUM_PULSE-1:0]            pulses;

  lpg_edge_det #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .sig_n_i({vsync_n_i, hsync_n_i}), .fall_o(falls)
  );
  assign hs_fall = falls[0];
  assign vs_fall = falls[1];

  // Overflow policy captured on the first edge after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!armed_q) mode_q <= sat_mode_i;
  end

  assign line_d = line_q | hs_fall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_d;
  end

  lpg_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .hs_fall_i(hs_fall), .vs_fall_i(vs_fall), .hold_mode_i(mode_q),
    .hcount_o(hcount_o), .vcount_o(vcount_o),
    .hcount_nxt_o(h_nxt), .advance_o(advance)
  );

  lpg_shadow_regs #(.CNT_W(CNT_W), .NREG(NUM_REG), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .load_i(vs_fall), .act_nxt_o(pos)
  );

  for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
    lpg_pulse_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .advance_i(advance), .hcount_nxt_i(h_nxt),
      .on_pos_i(pos[2*p]), .off_pos_i(pos[2*p+1]),
      .pulse_o(pulses[p])
    );
  end

  assign clamp_o     = pulses[PULSE_CLAMP];
  assign pblank_o    = pulses[PULSE_PBLANK];
  assign hblank_o    = pulses[PULSE_HBLANK];
  assign sample_en_o = line_q;
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync_n_i,
  input logic             vsync_n_i,
  input logic             mode_q,
  input logic [CNT_W-1:0] hcount_o,
  input logic [CNT_W-1:0] vcount_o,
  input logic             clamp_o,
  input logic             pblank_o,
  input logic             hblank_o,
  input logic             sample_en_o
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_h_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n_i) |=> hcount_o == '0);

  p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(hsync_n_i) && hcount_o != TOP) |=> hcount_o == $past(hcount_o) + 1'b1);

  p_v_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vsync_n_i) |=> vcount_o == '0);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && hcount_o == TOP && !$fell(hsync_n_i)) |=> hcount_o == '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && hcount_o == TOP && !$fell(hsync_n_i)) |=> hcount_o == TOP);

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && hcount_o == TOP && !$fell(hsync_n_i)) |=> $stable({clamp_o, pblank_o, hblank_o}));

  p_enable_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |=> sample_en_o);
endmodule

bind line_pulse_gen lpg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_n_i(hsync_n_i), .vsync_n_i(vsync_n_i),
  .mode_q(mode_q), .hcount_o(hcount_o), .vcount_o(vcount_o),
  .clamp_o(clamp_o), .pblank_o(pblank_o), .hblank_o(hblank_o),
  .sample_en_o(sample_en_o)
);

// File: tb/tb_line_pulse_gen.sv
`timescale 1ns/1ps
module tb_line_pulse_gen;
  logic        clk = 1'b0;
  logic        rst_n, sat_mode, hs_n, vs_n, wr_en;
  logic [2:0]  wr_addr;
  logic [11:0] wr_data;
  logic [11:0] hcount, vcount;
  logic        clamp, pblank, hblank, sample_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int m_h, m_v, m_mode, m_armed, m_line, m_hs_prev, m_vs_prev;
  int m_stage[6];
  int m_act[6];
  int m_p[3];

  always #2 clk = ~clk;

  line_pulse_gen dut (
    .clk(clk), .rst_n(rst_n), .sat_mode_i(sat_mode),
    .hsync_n_i(hs_n), .vsync_n_i(vs_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hcount_o(hcount), .vcount_o(vcount),
    .clamp_o(clamp), .pblank_o(pblank), .hblank_o(hblank),
    .sample_en_o(sample_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_h = 0; m_v = 0; m_line = 0; m_armed = 0;
    m_hs_prev = 1; m_vs_prev = 1;
    for (int i = 0; i < 6; i++) begin m_stage[i] = 0; m_act[i] = 0; end
    for (int i = 0; i < 3; i++) m_p[i] = 0;
  endtask

  task automatic model_step();
    int hf, vf, hn, adv;
    int na[6];
    if (!rst_n) begin
      model_reset();
      m_mode = sat_mode;
      return;
    end
    hf = (m_hs_prev == 1 && hs_n == 0);
    vf = (m_vs_prev == 1 && vs_n == 0);
    for (int i = 0; i < 6; i++) na[i] = vf ? m_stage[i] : m_act[i];
    if (hf)               hn = 0;
    else if (m_h == 4095) hn = m_mode ? 4095 : 0;
    else                  hn = m_h + 1;
    adv = hf || (m_h != 4095) || !m_mode;
    for (int p = 0; p < 3; p++)
      if (adv) begin
        if (hn == na[2*p])        m_p[p] = 1;
        else if (hn == na[2*p+1]) m_p[p] = 0;
      end
    if (vf)      m_v = 0;
    else if (hf) m_v = (m_v + 1) % 4096;
    m_h = hn;
    for (int i = 0; i < 6; i++) m_act[i] = na[i];
    if (wr_en && wr_addr < 6) m_stage[wr_addr] = wr_data;
    if (hf) m_line = 1;
    if (!m_armed) begin m_mode = sat_mode; m_armed = 1; end
    m_hs_prev = hs_n; m_vs_prev = vs_n;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    cycles++;
    @(negedge clk);
    chk("R2 hcount", hcount, m_h);
    chk("R3 vcount", vcount, m_v);
    chk("R7 clamp", clamp, m_p[0]);
    chk("R7 pblank", pblank, m_p[1]);
    chk("R7 hblank", hblank, m_p[2]);
    chk("R10 sample_en", sample_en, m_line);
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; sat_mode = mode; hs_n = 1'b1; vs_n = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    model_reset(); m_mode = mode;
    repeat (3) tick();
    chk("R1 reset hcount", hcount, 0);
    chk("R1 reset vcount", vcount, 0);
    chk("R1 reset pulses", {clamp, pblank, hblank}, 0);
    chk("R1 reset sample_en", sample_en, 0);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 12'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic sync(input bit h, input bit v, input int lowlen);
    hs_n = !h; vs_n = !v;
    repeat (lowlen) tick();
    hs_n = 1'b1; vs_n = 1'b1;
  endtask

  task automatic run_to(input int target);
    for (int g = 0; g < 5000; g++) begin
      if (hcount == 12'(target)) return;
      tick();
    end
  endtask

  initial begin
    // Phase A: wrap mode
    do_reset(1'b0);
    tick();
    wr(0, 10); wr(1, 30);      // clamp 10..30
    wr(2, 7);  wr(3, 7);       // pblank on == off
    wr(4, 0);  wr(5, 100);     // hblank 0..100
    wr(6, 99);                 // ignored address
    tick();
    sync(1, 1, 1);
    chk("R2 restart", hcount, 0);
    chk("R3 both syncs", vcount, 0);
    chk("R10 enable after hsync", sample_en, 1);
    chk("R9 new hblank at first pixel", hblank, 1);
    run_to(7);  chk("R7 equal on/off turns on", pblank, 1);
    run_to(10); chk("R7 clamp on", clamp, 1);
    run_to(30); chk("R7 clamp off", clamp, 0);
    wr(0, 50);
    repeat (20) tick();
    sync(1, 0, 1);
    chk("R3 line step", vcount, 1);
    run_to(10); chk("R9 old position kept", clamp, 1);
    run_to(40); chk("R9 clamp off old", clamp, 0);
    sync(1, 1, 3);
    chk("R2 level does not restart", hcount, 2);
    run_to(10); chk("R9 new position not at old", clamp, 0);
    run_to(50); chk("R9 new position applied", clamp, 1);
    sync(1, 0, 1);
    repeat (4096) tick();
    chk("R4 wrap to zero", hcount, 0);
    tick();
    chk("R4 continues", hcount, 1);

    // Phase B: hold mode, mode input changed after capture
    do_reset(1'b1);
    tick();
    sat_mode = 1'b0;           // must be ignored
    wr(0, 4095); wr(1, 4095);  // clamp on at top
    wr(4, 4000); wr(5, 0);     // hblank from 4000
    sync(1, 1, 1);
    repeat (4100) tick();
    chk("R5 held at top", hcount, 4095);
    chk("R6 mode change ignored", hcount, 4095);
    chk("R8 clamp stays on", clamp, 1);
    chk("R8 hblank stays on", hblank, 1);
    chk("R8 sample_en stays", sample_en, 1);
    repeat (10) tick();
    chk("R8 still frozen", {clamp, hblank}, 3);
    sync(1, 0, 1);
    chk("R5 released by hsync", hcount, 0);
    tick();
    chk("R5 counts again", hcount, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected<190000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule